// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets logic on a synchronous clock read and write an external asynchronous static RAM of 2048 bytes. A host raises `req` for one cycle with the direction, an 11-bit address and the write byte. The controller then drives the memory's active-low chip-enable, write-enable and output-enable lines, its address lines and a split data bus. The data bus has a separate output-enable for the tristate pad.

All memory timing is set as nanosecond parameters. The block converts each one to a whole number of clock cycles using max(1, ceil(t_ns / CLK_NS)). With the default 4 ns clock, a write takes 25 cycles from acceptance to its completion pulse and a read takes 26. The block handles one access at a time. While an access is running, further requests are dropped. The completion pulse `done` lasts one cycle. On a read, `rdata` is valid in that cycle and stays unchanged until the next read completes.

Top module: `sram_access_ctrl`

## Requirements
- R1: While reset is active, and at any time the controller is idle, chip-enable, write-enable and output-enable are high, the pad driver enable is low and `done` is low.
- R2: A write accepted at a clock edge holds chip-enable low and write-enable high for 5 setup cycles. Write-enable is then low for 15 cycles (at least 60 ns), and output-enable stays high for the whole write.
- R3: The address pins change only at acceptance of a request, in a cycle where write-enable is high and was high in the cycle before. They keep the accepted address until the next accepted request.
- R4: The pad driver is enabled from the second low cycle of write-enable until the end of the 3 cycles that follow write-enable's return high. While it is enabled it presents the accepted write byte, and it is never on while output-enable is low.
- R5: After a write, chip-enable rises 3 cycles after write-enable rises. `done` pulses 25 cycles after acceptance, which covers the 100 ns write cycle minimum.
- R6: A read holds chip-enable and output-enable low with write-enable high for 25 cycles (the longest of the 100 ns address, 100 ns chip-enable and 40 ns output-enable access times). The data bus is captured into `rdata` at the end of that window.
- R7: After a read, chip-enable and output-enable are high for at least one cycle before `done` pulses, 26 cycles after acceptance. No new access begins before the cycle after `done`.
- R8: A request that arrives while an access is in progress is ignored. It changes neither the address pins, the strobes, the stored data nor the next access.
- R9: `done` is high for exactly one cycle per access. `rdata` keeps the value of the most recent completed read through any later writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | Access request, sampled while idle |
| we | input | 1 | Direction of the request: 1 write, 0 read |
| addr | input | 11 | Byte address of the request |
| wdata | input | 8 | Byte to write |
| rdata | output | 8 | Byte captured by the last completed read |
| done | output | 1 | One-cycle completion pulse |
| sram_addr | output | 11 | Memory address lines |
| sram_ce_n | output | 1 | Memory chip-enable, active low |
| sram_we_n | output | 1 | Memory write-enable, active low |
| sram_oe_n | output | 1 | Memory output-enable, active low |
| sram_dq_out | output | 8 | Data toward the memory pad |
| sram_dq_in | input | 8 | Data from the memory pad |
| sram_dq_oe | output | 1 | Enable for the pad's tristate driver |

## Verification
The bench applies writes at both ends of the address range and in the middle, reads of bytes that were written and of bytes left at their initial pattern, and reads followed at once by a write. These patterns separate wrong strobe windows, wrong address holding and lost or misplaced writes. The memory model on the bench side returns the inverted byte until just before the 100 ns access window closes, so a capture made one cycle early is caught. Some accesses keep `req` asserted with a different address and direction for almost their whole length. This shows whether a busy controller ignores requests or starts a spurious access afterwards.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_W_SETUP  = 3'd1,
    PH_W_STROBE = 3'd2,
    PH_W_DRIVE  = 3'd3,
    PH_W_HOLD   = 3'd4,
    PH_W_END    = 3'd5,
    PH_R_ACCESS = 3'd6,
    PH_R_END    = 3'd7
  } phase_e;

  // Whole clock cycles covering t_ns, never fewer than one.
  function automatic int to_cycles(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_len,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = load_len - CNT_W'(1);
    else      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int CNT_W   = 5,
  parameter int SU_C    = 5,
  parameter int WP_C    = 15,
  parameter int HD_C    = 3,
  parameter int WEND_C  = 2,
  parameter int RD_C    = 25,
  parameter int REND_C  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             we,
  input  logic             ph_expire,
  output phase_e           phase_q,
  output phase_e           phase_d,
  output logic             ph_load,
  output logic [CNT_W-1:0] ph_len,
  output logic             accept,
  output logic             capture,
  output logic             finish
);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:     if (req) phase_d = we ? PH_W_SETUP : PH_R_ACCESS;
      PH_W_SETUP:  if (ph_expire) phase_d = PH_W_STROBE;
      PH_W_STROBE: if (ph_expire) phase_d = PH_W_DRIVE;
      PH_W_DRIVE:  if (ph_expire) phase_d = PH_W_HOLD;
      PH_W_HOLD:   if (ph_expire) phase_d = PH_W_END;
      PH_W_END:    if (ph_expire) phase_d = PH_IDLE;
      PH_R_ACCESS: if (ph_expire) phase_d = PH_R_END;
      PH_R_END:    if (ph_expire) phase_d = PH_IDLE;
      default:     phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    unique case (phase_d)
      PH_W_SETUP:  ph_len = CNT_W'(SU_C);
      PH_W_STROBE: ph_len = CNT_W'(1);
      PH_W_DRIVE:  ph_len = CNT_W'(WP_C - 1);
      PH_W_HOLD:   ph_len = CNT_W'(HD_C);
      PH_W_END:    ph_len = CNT_W'(WEND_C);
      PH_R_ACCESS: ph_len = CNT_W'(RD_C);
      PH_R_END:    ph_len = CNT_W'(REND_C);
      default:     ph_len = CNT_W'(1);
    endcase
    ph_load = (phase_d != phase_q) && (phase_d != PH_IDLE);
    accept  = (phase_q == PH_IDLE) && req;
    capture = (phase_q == PH_R_ACCESS) && ph_expire;
    finish  = ((phase_q == PH_W_END) || (phase_q == PH_R_END)) && ph_expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  // R8: a busy phase is left only when the timer reports its interval used up
  // R8
  phase_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && phase_d != phase_q) |-> ph_expire);

endmodule

// File: rtl/sram_pin_regs.sv
module sram_pin_regs
  import sram_seq_pkg::*;
#(
  parameter int AW   = 11,
  parameter int DW   = 8,
  parameter int WP_C = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase_d,
  input  logic          accept,
  input  logic          capture,
  input  logic          finish,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic [DW-1:0] sram_dq_in,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce_n,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [DW-1:0] sram_dq_out,
  output logic          sram_dq_oe,
  output logic [DW-1:0] rdata,
  output logic          done
);

  logic ce_n_d, we_n_d, oe_n_d, dq_oe_d;

  always_comb begin
    ce_n_d  = !(phase_d inside {PH_W_SETUP, PH_W_STROBE, PH_W_DRIVE,
                                PH_W_HOLD, PH_R_ACCESS});
    we_n_d  = !(phase_d inside {PH_W_STROBE, PH_W_DRIVE});
    oe_n_d  = (phase_d != PH_R_ACCESS);
    dq_oe_d = (phase_d inside {PH_W_DRIVE, PH_W_HOLD});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_ce_n  <= 1'b1;
      sram_we_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
      sram_dq_oe <= 1'b0;
      done       <= 1'b0;
    end else begin
      sram_ce_n  <= ce_n_d;
      sram_we_n  <= we_n_d;
      sram_oe_n  <= oe_n_d;
      sram_dq_oe <= dq_oe_d;
      done       <= finish;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_addr   <= '0;
      sram_dq_out <= '0;
    end else if (accept) begin
      sram_addr   <= host_addr;
      sram_dq_out <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (capture) rdata <= sram_dq_in;
  end

  // Observation counter for the strobe width check
  logic [7:0] we_lo_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          we_lo_len <= '0;
    else if (!sram_we_n) we_lo_len <= (we_lo_len == 8'hFF) ? we_lo_len : we_lo_len + 8'd1;
    else                 we_lo_len <= '0;
  end

  // R2
  we_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_ce_n && sram_oe_n));

  // R2
  we_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_lo_len >= 8'(WP_C)));

  // R3
  addr_move_we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_addr != $past(sram_addr)) |-> (sram_we_n && $past(sram_we_n)));

  // R4
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);

  // R4
  drive_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (!sram_we_n && !$past(sram_we_n)));

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (sram_dq_oe && !sram_ce_n));

  // R7
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_oe_n) |-> (sram_ce_n && !done));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl
  import sram_seq_pkg::*;
#(
  parameter int CLK_NS = 4,
  parameter int AW     = 11,
  parameter int DW     = 8,
  parameter int T_WC   = 100,
  parameter int T_WP   = 60,
  parameter int T_AW   = 80,
  parameter int T_DW   = 30,
  parameter int T_DH   = 10,
  parameter int T_WR   = 10,
  parameter int T_RC   = 100,
  parameter int T_AA   = 100,
  parameter int T_ACE  = 100,
  parameter int T_OE   = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          done,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce_n,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [DW-1:0] sram_dq_out,
  input  logic [DW-1:0] sram_dq_in,
  output logic          sram_dq_oe
);

  localparam int WP_C   = imax(2, imax(to_cycles(T_WP, CLK_NS), to_cycles(T_DW, CLK_NS) + 1));
  localparam int SU_C   = imax(1, to_cycles(T_AW, CLK_NS) - WP_C);
  localparam int HD_C   = imax(to_cycles(T_DH, CLK_NS), to_cycles(T_WR, CLK_NS));
  localparam int WEND_C = imax(1, to_cycles(T_WC, CLK_NS) - (SU_C + WP_C + HD_C));
  localparam int RD_C   = imax(to_cycles(T_AA, CLK_NS),
                               imax(to_cycles(T_ACE, CLK_NS), to_cycles(T_OE, CLK_NS)));
  localparam int REND_C = imax(1, to_cycles(T_RC, CLK_NS) - RD_C);
  localparam int LEN_MAX = imax(imax(imax(SU_C, WP_C), imax(HD_C, WEND_C)), imax(RD_C, REND_C));
  localparam int CNT_W  = $clog2(LEN_MAX + 1);

  // Reset synchronizer: assert at once, release on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  phase_e           phase_q, phase_d;
  logic             ph_load, ph_expire;
  logic [CNT_W-1:0] ph_len;
  logic             accept, capture, finish;

  sram_seq_fsm #(
    .CNT_W (CNT_W), .SU_C (SU_C), .WP_C (WP_C), .HD_C (HD_C),
    .WEND_C(WEND_C), .RD_C (RD_C), .REND_C(REND_C)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req       (req),
    .we        (we),
    .ph_expire (ph_expire),
    .phase_q   (phase_q),
    .phase_d   (phase_d),
    .ph_load   (ph_load),
    .ph_len    (ph_len),
    .accept    (accept),
    .capture   (capture),
    .finish    (finish)
  );

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (ph_load),
    .load_len (ph_len),
    .expire   (ph_expire)
  );

  sram_pin_regs #(.AW(AW), .DW(DW), .WP_C(WP_C)) u_pins (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .phase_d     (phase_d),
    .accept      (accept),
    .capture     (capture),
    .finish      (finish),
    .host_addr   (addr),
    .host_wdata  (wdata),
    .sram_dq_in  (sram_dq_in),
    .sram_addr   (sram_addr),
    .sram_ce_n   (sram_ce_n),
    .sram_we_n   (sram_we_n),
    .sram_oe_n   (sram_oe_n),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe),
    .rdata       (rdata),
    .done        (done)
  );

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase_q == PH_IDLE) |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe));

endmodule

// File: tb/test_sram_access_ctrl.sv
`timescale 1ns/1ps
module test_sram_access_ctrl;

  localparam int CLK_NS = 4;

  logic        clk;
  logic        rst_n;
  logic        req, we;
  logic [10:0] addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        done;
  logic [10:0] sram_addr;
  logic        sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [7:0]  sram_dq_out, sram_dq_in;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  sram_access_ctrl i_sram_access_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .done(done), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_dq_out(sram_dq_out),
    .sram_dq_in(sram_dq_in), .sram_dq_oe(sram_dq_oe)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  function automatic int ceil_cyc(input int t);
    return (t + CLK_NS - 1) / CLK_NS;
  endfunction

  // Expected windows, from the requirement timings
  int e_wp, e_su, e_hd, e_wend, e_rd, e_rend;

  // Behavioural memory on the pad side, plus the bench's own expected contents
  logic [7:0] mem    [0:2047];
  logic [7:0] golden [0:2047];
  logic [7:0] pend;
  logic       we_prev;
  int         rd_run;

  always @(negedge clk) begin : pad_model
    int rc;
    rc = (!sram_ce_n && !sram_oe_n && sram_we_n) ? rd_run + 1 : 0;
    rd_run <= rc;
    // data is valid only in the last cycle before the 100 ns window closes
    if (rc > 0 && ((rc - 1) * CLK_NS + 2) >= (100 - CLK_NS))
      sram_dq_in <= mem[sram_addr];
    else
      sram_dq_in <= ~mem[sram_addr];
    if (!we_prev && sram_we_n) mem[sram_addr] <= pend;
    if (!sram_we_n && !sram_ce_n && sram_dq_oe) pend <= sram_dq_out;
    we_prev <= sram_we_n;
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One access; optionally keeps a conflicting request up while busy (R8)
  task automatic run_access(input bit w, input logic [10:0] a, input logic [7:0] d,
                            input bit hold_req, input logic [10:0] a2);
    int total;
    logic [7:0] last_rd;
    last_rd = rdata;
    total = w ? (e_su + e_wp + e_hd + e_wend) : (e_rd + e_rend);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk); // cycle 0 after the accepting edge
    for (int c = 0; c <= total + 1; c++) begin
      logic ece, ewe, eoe, edoe, edone;
      if (c > 0) @(negedge clk);
      if (hold_req && c < total) begin
        req = 1'b1; we = ~w; addr = a2; wdata = ~d;
      end else begin
        req = 1'b0;
      end
      if (w) begin
        ece  = !(c < e_su + e_wp + e_hd);
        ewe  = !(c >= e_su && c < e_su + e_wp);
        eoe  = 1'b1;
        edoe = (c >= e_su + 1 && c < e_su + e_wp + e_hd);
      end else begin
        ece  = !(c < e_rd);
        ewe  = 1'b1;
        eoe  = !(c < e_rd);
        edoe = 1'b0;
      end
      edone = (c == total);
      // R2 R5 R6 R7: strobe windows; R1 covers the idle cycle after done
      chk(w ? "R2" : "R6", "ce_n", sram_ce_n, ece);
      chk(w ? "R2" : "R6", "we_n", sram_we_n, ewe);
      chk(w ? "R2" : "R7", "oe_n", sram_oe_n, eoe);
      chk("R4", "dq_oe", sram_dq_oe, edoe);
      chk(w ? "R5" : "R7", "done", done, edone);
      if (c <= total) chk("R3", "address", sram_addr, a);
      if (edoe) chk("R4", "dq_out", sram_dq_out, d);
      if (c == total) begin
        if (w) begin
          golden[a] = d;
          chk("R9", "rdata kept over write", rdata, last_rd);
        end else begin
          chk("R6", "rdata", rdata, golden[a]);
        end
      end
      if (c == total + 1) chk("R1", "idle after done", {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, done}, 5'b11100);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    e_wp   = (ceil_cyc(60) > ceil_cyc(30) + 1) ? ceil_cyc(60) : ceil_cyc(30) + 1;
    e_su   = ceil_cyc(80) - e_wp;
    e_hd   = ceil_cyc(10);
    e_wend = ceil_cyc(100) - (e_su + e_wp + e_hd);
    e_rd   = ceil_cyc(100);
    e_rend = 1;
    for (int i = 0; i < 2048; i++) begin
      mem[i]    = 8'(i * 7 + 3);
      golden[i] = 8'(i * 7 + 3);
    end
    pend = 8'h00; we_prev = 1'b1; rd_run = 0; sram_dq_in = 8'h00;
    req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    req = 1'b1; // must be ignored in reset
    @(negedge clk);
    // R1: reset state
    chk("R1", "reset pins", {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, done}, 5'b11100);
    chk("R1", "reset rdata", rdata, 8'h00);
    req = 1'b0;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", "idle pins", {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, done}, 5'b11100);

    run_access(1'b1, 11'h000, 8'h5A, 1'b0, 11'h000);
    run_access(1'b1, 11'h7FF, 8'hC3, 1'b0, 11'h000);
    run_access(1'b0, 11'h7FF, 8'h00, 1'b0, 11'h000);
    run_access(1'b0, 11'h000, 8'h00, 1'b0, 11'h000);
    run_access(1'b0, 11'h123, 8'h00, 1'b0, 11'h000);
    // R8: conflicting request held while busy
    run_access(1'b1, 11'h400, 8'h99, 1'b1, 11'h2AA);
    run_access(1'b0, 11'h400, 8'h00, 1'b1, 11'h155);
    run_access(1'b0, 11'h2AA, 8'h00, 1'b0, 11'h000);
    run_access(1'b0, 11'h155, 8'h00, 1'b0, 11'h000);
    // R7: read directly followed by write, then R9 rdata held
    run_access(1'b0, 11'h001, 8'h00, 1'b0, 11'h000);
    run_access(1'b1, 11'h001, 8'h3C, 1'b0, 11'h000);
    run_access(1'b1, 11'h002, 8'hF0, 1'b0, 11'h000);
    run_access(1'b0, 11'h001, 8'h00, 1'b0, 11'h000);
    run_access(1'b0, 11'h002, 8'h00, 1'b0, 11'h000);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule